// File: doc/BRIEF.md
# I2C Slave Rate and Pin Configuration Front End

This block sits in front of an I2C slave byte engine. It keeps a small configuration register (enable, a two-bit bus-rate code, a stop-interrupt enable and a pin-pair select). From the system clock it produces a sample strobe and, within each bit, a sample index together with an end-of-bit strobe. The prescale factor and the number of samples per bit both follow from the rate code and from a flag that tells whether the system clock runs at its fast (12 MHz) or slow (6 MHz) setting.

It also routes the serial clock and data lines between the byte engine and one of two pad pairs. It raises a one-cycle interrupt pulse when a stop-status level from the engine rises while the stop interrupt is enabled. The byte engine writes the register through a single write strobe. Downstream logic reads the held value on `cfg_q`.

Top module: `i2cs_rate_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `cfg_q` is 0, `sample_stb`, `bit_stb` and `stop_irq` are 0, `scl_in` and `sda_in` are 1, and no pad drive enable is set.
- R2: A write stores enable in bit 0, the rate code in bits 2:1, the stop-interrupt enable in bit 3 and the pin select in bit 4. Bits 7:5 of `cfg_q` always read 0, whatever was written there.
- R3: While enable (bit 0) is 1, a write leaves the pin select unchanged. A write that sets enable from the disabled state takes the written pin select.
- R4: With enable set, `sample_stb` pulses once every P cycles. P is 8 for rate codes 00 and 10 and 2 for code 01 when `sys_fast` is 1, and 4, 4 and 1 for those codes when `sys_fast` is 0. Without enable there are no strobes.
- R5: `samp_idx` counts sample strobes from 0 to S-1 and wraps, with S = 16 for codes 00 and 01 and S = 32 for code 10. `bit_stb` pulses together with the strobe at index S-1.
- R6: With rate code 11 no sample or bit strobes are produced.
- R7: A write that changes the rate code or sets enable, or a change of `sys_fast`, restarts the timing: the first strobe comes in the P-th cycle after the edge that applies the change.
- R8: When `stop_status` goes from 0 to 1 while the stop-interrupt enable is set, `stop_irq` is 1 for exactly one cycle, in the cycle after the first clock edge that samples the 1.
- R9: No further `stop_irq` arises while `stop_status` stays 1, and none arises on a rise while the stop-interrupt enable is 0.
- R10: While enabled, `scl_in`/`sda_in` follow pad pair `sel` (index 0 or 1 of the pad vectors), and `eng_scl_low`/`eng_sda_low` set the drive enable of that pair only. While disabled, both inputs read 1 and no drive enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_fast | input | 1 | 1 when the system clock runs at its fast setting |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_q | output | 8 | Held configuration value |
| sample_stb | output | 1 | One-cycle sample strobe |
| bit_stb | output | 1 | Strobe marking the last sample of a bit |
| samp_idx | output | 5 | Index of the current sample within the bit |
| stop_status | input | 1 | Stop-status level from the byte engine |
| stop_irq | output | 1 | Stop interrupt pulse |
| pad_scl_i | input | 2 | Clock line level at each pad pair |
| pad_sda_i | input | 2 | Data line level at each pad pair |
| pad_scl_oe | output | 2 | Clock pull-low enable for each pad pair |
| pad_sda_oe | output | 2 | Data pull-low enable for each pad pair |
| eng_scl_low | input | 1 | Engine request to pull the clock line low |
| eng_sda_low | input | 1 | Engine request to pull the data line low |
| scl_in | output | 1 | Selected clock line level to the engine |
| sda_in | output | 1 | Selected data line level to the engine |

## Verification
The properties assume that `stop_status` and the pad and engine inputs are synchronous to `clk`, and that `sys_fast` only changes between runs of strobes, because a toggle restarts the timing. The stimulus drives every input one time unit after a falling edge. It changes `sys_fast` only a few times, each followed by hundreds of cycles, so that every prescale value is seen in steady state. Stop-status pulses are held several cycles long so that a held level can be told apart from a fresh rise.

// File: rtl/i2cs_rc_pkg.sv
package i2cs_rc_pkg;

  typedef logic [1:0] rate_t;

  localparam rate_t RATE_STD100 = 2'b00;
  localparam rate_t RATE_FAST   = 2'b01;
  localparam rate_t RATE_STD50  = 2'b10;
  localparam rate_t RATE_RSVD   = 2'b11;

  // field positions inside the write word
  localparam int BIT_EN   = 0;
  localparam int RATE_LO  = 1;
  localparam int BIT_IE   = 3;
  localparam int BIT_SEL  = 4;

  typedef struct packed {
    logic  sel;
    logic  ie;
    rate_t rate;
    logic  en;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // system-clock cycles per sample strobe; 0 marks an unusable code
  function automatic int unsigned prescale_of(rate_t r, logic fast);
    case (r)
      RATE_STD100: return fast ? 8 : 4;
      RATE_FAST:   return fast ? 2 : 1;
      RATE_STD50:  return fast ? 8 : 4;
      default:     return 0;
    endcase
  endfunction

  // sample strobes per bit period
  function automatic int unsigned spb_of(rate_t r);
    case (r)
      RATE_STD100: return 16;
      RATE_FAST:   return 16;
      RATE_STD50:  return 32;
      default:     return 0;
    endcase
  endfunction

endpackage

// File: rtl/i2cs_cfg_reg.sv
module i2cs_cfg_reg
  import i2cs_rc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          sys_fast,
  output cfg_t          cfg,
  output logic          fast_q,
  output logic          resync
);

  cfg_t wr_val;
  logic rate_chg;
  logic en_rise;
  logic unused_rsvd;

  assign unused_rsvd = ^wdata[DW-1:CFG_W];

  always_comb begin
    wr_val.en   = wdata[BIT_EN];
    wr_val.rate = wdata[RATE_LO +: 2];
    wr_val.ie   = wdata[BIT_IE];
    wr_val.sel  = cfg.en ? cfg.sel : wdata[BIT_SEL];
  end

  assign rate_chg = we && (wr_val.rate != cfg.rate);
  assign en_rise  = we && wr_val.en && !cfg.en;
  assign resync   = rate_chg || en_rise || (sys_fast != fast_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      fast_q <= 1'b0;
    end else begin
      fast_q <= sys_fast;
      if (we) cfg <= wr_val;
    end
  end

endmodule

// File: rtl/i2cs_rate_gen.sv
module i2cs_rate_gen
  import i2cs_rc_pkg::*;
#(
  parameter int PRE_W = 4,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  rate_t            rate,
  input  logic             fast_q,
  input  logic             resync,
  output logic             sample_stb,
  output logic             bit_stb,
  output logic [IDX_W-1:0] samp_idx
);

  logic             active;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_lim;
  logic [IDX_W-1:0] idx_lim;

  assign active = en && (rate != RATE_RSVD);

  always_comb begin
    pre_lim = '0;
    idx_lim = '0;
    if (active) begin
      pre_lim = PRE_W'(prescale_of(rate, fast_q) - 1);
      idx_lim = IDX_W'(spb_of(rate) - 1);
    end
  end

  assign sample_stb = active && (pre_cnt == pre_lim);
  assign bit_stb    = sample_stb && (samp_idx == idx_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      samp_idx <= '0;
    end else if (resync || !active) begin
      pre_cnt  <= '0;
      samp_idx <= '0;
    end else begin
      pre_cnt <= sample_stb ? '0 : pre_cnt + 1'b1;
      if (sample_stb) samp_idx <= bit_stb ? '0 : samp_idx + 1'b1;
    end
  end

endmodule

// File: rtl/i2cs_pin_mux.sv
module i2cs_pin_mux #(
  parameter int NP = 2
) (
  input  logic          en,
  input  logic          sel,
  input  logic [NP-1:0] pad_scl_i,
  input  logic [NP-1:0] pad_sda_i,
  input  logic          eng_scl_low,
  input  logic          eng_sda_low,
  output logic [NP-1:0] pad_scl_oe,
  output logic [NP-1:0] pad_sda_oe,
  output logic          scl_in,
  output logic          sda_in
);

  logic [NP-1:0] pick;

  for (genvar k = 0; k < NP; k++) begin : g_pair
    assign pick[k]       = en && (int'(sel) == k);
    assign pad_scl_oe[k] = pick[k] && eng_scl_low;
    assign pad_sda_oe[k] = pick[k] && eng_sda_low;
  end

  assign scl_in = (pick & pad_scl_i) != '0 || !en;
  assign sda_in = (pick & pad_sda_i) != '0 || !en;

endmodule

// File: rtl/i2cs_stop_irq.sv
module i2cs_stop_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ie,
  input  logic stop_status,
  output logic stop_rise,
  output logic stop_irq
);

  logic stop_q;

  assign stop_rise = stop_status && !stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q   <= 1'b0;
      stop_irq <= 1'b0;
    end else begin
      stop_q   <= stop_status;
      stop_irq <= stop_rise && ie;
    end
  end

endmodule

// File: rtl/i2cs_rate_ctrl.sv
module i2cs_rate_ctrl
  import i2cs_rc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NP    = 2,
  parameter int PRE_W = 4,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_fast,
  input  logic             cfg_we,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_q,
  output logic             sample_stb,
  output logic             bit_stb,
  output logic [IDX_W-1:0] samp_idx,
  input  logic             stop_status,
  output logic             stop_irq,
  input  logic [NP-1:0]    pad_scl_i,
  input  logic [NP-1:0]    pad_sda_i,
  output logic [NP-1:0]    pad_scl_oe,
  output logic [NP-1:0]    pad_sda_oe,
  input  logic             eng_scl_low,
  input  logic             eng_sda_low,
  output logic             scl_in,
  output logic             sda_in
);

  localparam int PAD_W = DW - CFG_W;

  cfg_t cfg;
  logic fast_q;
  logic resync_w;
  logic stop_rise_w;

  i2cs_cfg_reg #(.DW(DW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .sys_fast (sys_fast),
    .cfg      (cfg),
    .fast_q   (fast_q),
    .resync   (resync_w)
  );

  assign cfg_q = {{PAD_W{1'b0}}, cfg};

  i2cs_rate_gen #(.PRE_W(PRE_W), .IDX_W(IDX_W)) u_rate (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (cfg.en),
    .rate       (cfg.rate),
    .fast_q     (fast_q),
    .resync     (resync_w),
    .sample_stb (sample_stb),
    .bit_stb    (bit_stb),
    .samp_idx   (samp_idx)
  );

  i2cs_pin_mux #(.NP(NP)) u_mux (
    .en          (cfg.en),
    .sel         (cfg.sel),
    .pad_scl_i   (pad_scl_i),
    .pad_sda_i   (pad_sda_i),
    .eng_scl_low (eng_scl_low),
    .eng_sda_low (eng_sda_low),
    .pad_scl_oe  (pad_scl_oe),
    .pad_sda_oe  (pad_sda_oe),
    .scl_in      (scl_in),
    .sda_in      (sda_in)
  );

  i2cs_stop_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ie          (cfg.ie),
    .stop_status (stop_status),
    .stop_rise   (stop_rise_w),
    .stop_irq    (stop_irq)
  );

endmodule

// File: rtl/i2cs_rate_ctrl_chk.sv
module i2cs_rate_ctrl_chk
  import i2cs_rc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NP    = 2,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DW-1:0]    cfg_q,
  input logic             sample_stb,
  input logic             bit_stb,
  input logic [IDX_W-1:0] samp_idx,
  input logic             stop_status,
  input logic             stop_irq,
  input logic             stop_rise_w,
  input logic [NP-1:0]    pad_scl_oe,
  input logic [NP-1:0]    pad_sda_oe,
  input logic             fast_q,
  input logic             resync_w
);

  rate_t       rate_c;
  int unsigned pre_c;
  int unsigned spb_c;

  assign rate_c = cfg_q[RATE_LO +: 2];
  assign pre_c  = prescale_of(rate_c, fast_q);
  assign spb_c  = spb_of(rate_c);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[DW-1:CFG_W] == '0);

  p_sel_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[BIT_EN] && $past(cfg_q[BIT_EN])) |-> $stable(cfg_q[BIT_SEL]));

  p_stb_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !resync_w && pre_c > 1) |=> !sample_stb);

  p_bit_on_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> sample_stb);

  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[BIT_EN] && spb_c != 0) |-> (int'(samp_idx) < int'(spb_c)));

  p_quiet_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_c == RATE_RSVD || !cfg_q[BIT_EN]) |-> !sample_stb);

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq |-> ($past(stop_rise_w) && $past(cfg_q[BIT_IE])));

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq |=> !stop_irq);

  p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_status && $past(stop_status)) |=> !stop_irq);

  p_one_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pad_scl_oe) && $onehot0(pad_sda_oe));

endmodule

bind i2cs_rate_ctrl i2cs_rate_ctrl_chk #(.DW(DW), .NP(NP), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_q       (cfg_q),
  .sample_stb  (sample_stb),
  .bit_stb     (bit_stb),
  .samp_idx    (samp_idx),
  .stop_status (stop_status),
  .stop_irq    (stop_irq),
  .stop_rise_w (stop_rise_w),
  .pad_scl_oe  (pad_scl_oe),
  .pad_sda_oe  (pad_sda_oe),
  .fast_q      (fast_q),
  .resync_w    (resync_w)
);

// File: tb/sim_i2cs_rate_ctrl.sv
`timescale 1ns/100ps
module sim_i2cs_rate_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_fast = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_q;
  logic       sample_stb, bit_stb;
  logic [4:0] samp_idx;
  logic       stop_status = 1'b0;
  logic       stop_irq;
  logic [1:0] pad_scl_i = 2'b11, pad_sda_i = 2'b11;
  logic [1:0] pad_scl_oe, pad_sda_oe;
  logic       eng_scl_low = 1'b0, eng_sda_low = 1'b0;
  logic       scl_in, sda_in;

  always #2.5 clk = ~clk;

  i2cs_rate_ctrl u0 (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model state
  bit     m_en, m_ie, m_sel, m_fast, m_stop_prev, m_irq;
  int     m_rate;
  longint m_since;
  int     irq_seen = 0;
  int     stb_seen = 0;

  function automatic int per_of(int r, bit f);
    if (r == 1) return f ? 2 : 1;
    if (r == 3) return 0;
    return f ? 8 : 4;
  endfunction

  function automatic int samples_of(int r);
    return (r == 2) ? 32 : 16;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_ie = 0; m_sel = 0; m_fast = 0; m_stop_prev = 0;
      m_irq = 0; m_rate = 0; m_since = 0;
    end else begin
      bit rs;
      rs = (m_fast != sys_fast);
      m_irq = stop_status && !m_stop_prev && m_ie;
      m_stop_prev = stop_status;
      if (cfg_we) begin
        if (int'(cfg_wdata[2:1]) != m_rate) rs = 1;
        if (cfg_wdata[0] && !m_en) rs = 1;
        if (!m_en) m_sel = cfg_wdata[4];
        m_en = cfg_wdata[0];
        m_rate = int'(cfg_wdata[2:1]);
        m_ie = cfg_wdata[3];
      end
      m_fast = sys_fast;
      m_since = rs ? 0 : m_since + 1;
    end
  end

  // compare on every falling edge, before inputs move
  always @(negedge clk) begin
    if (!done) begin
      bit act, e_stb, e_bit;
      int p, s, e_idx;
      bit [7:0] e_cfg;
      bit e_scl, e_sda;
      bit [1:0] e_soe, e_doe;
      p = per_of(m_rate, m_fast);
      s = samples_of(m_rate);
      act = m_en && m_rate != 3;
      e_stb = act && (((m_since + 1) % p) == 0);
      e_idx = act ? int'((m_since / p) % s) : 0;
      e_bit = e_stb && (e_idx == s - 1);
      e_cfg = {3'b000, m_sel, m_ie, 2'(m_rate), m_en};
      e_scl = m_en ? pad_scl_i[m_sel] : 1'b1;
      e_sda = m_en ? pad_sda_i[m_sel] : 1'b1;
      e_soe = '0; e_doe = '0;
      if (m_en) begin
        e_soe[m_sel] = eng_scl_low;
        e_doe[m_sel] = eng_sda_low;
      end
      if (!rst_n) begin
        chk(cfg_q == 8'h00 && !sample_stb && !stop_irq, "R1 reset outputs", int'(cfg_q), 0);
        chk(scl_in && sda_in && pad_scl_oe == 0 && pad_sda_oe == 0, "R1 reset lines",
            int'({scl_in, sda_in, pad_scl_oe, pad_sda_oe}), 6'b110000);
      end else begin
        chk(sample_stb == e_stb, act ? "R4 sample_stb" : "R6 sample_stb", sample_stb, e_stb);
        chk(bit_stb == e_bit, "R5 bit_stb", bit_stb, e_bit);
        if (act) chk(int'(samp_idx) == e_idx, "R5 samp_idx", samp_idx, e_idx);
        chk(cfg_q == e_cfg, "R2 cfg_q", cfg_q, e_cfg);
        chk(stop_irq == m_irq, m_irq ? "R8 stop_irq" : "R9 stop_irq", stop_irq, m_irq);
        chk(scl_in == e_scl && sda_in == e_sda, "R10 line inputs",
            int'({scl_in, sda_in}), int'({e_scl, e_sda}));
        chk(pad_scl_oe == e_soe && pad_sda_oe == e_doe, "R10 drive enables",
            int'({pad_scl_oe, pad_sda_oe}), int'({e_soe, e_doe}));
        if (stop_irq) irq_seen++;
        if (sample_stb) stb_seen++;
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      pad_scl_i   = 2'($urandom);
      pad_sda_i   = 2'($urandom);
      eng_scl_low = 1'($urandom);
      eng_sda_low = 1'($urandom);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // R7: write, then count cycles until the first strobe
  task automatic wr_first(input logic [7:0] d, input int exp_p, input string tag);
    int n;
    bit got;
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    n = 1; got = sample_stb;
    #1 cfg_we = 1'b0;
    while (!got && n < 1000) begin
      @(negedge clk);
      n++; got = sample_stb;
    end
    chk(n == exp_p, tag, n, exp_p);
  endtask

  initial begin
    step(4);
    @(negedge clk); #1 rst_n = 1'b1;
    step(3);
    wr_first(8'h11, 8, "R7 enable rate00 fast");
    step(300);
    wr(8'h01);
    step(5);
    chk(cfg_q[4] == 1'b1, "R3 select held while enabled", cfg_q[4], 1);
    wr_first(8'h13, 2, "R7 change to rate01 fast");
    step(100);
    wr_first(8'h15, 8, "R7 change to rate10 fast");
    step(600);
    @(negedge clk); #1 sys_fast = 1'b0;
    step(300);
    wr_first(8'h13, 1, "R7 change to rate01 slow");
    step(60);
    wr(8'h17);
    stb_seen = 0;
    step(100);
    chk(stb_seen == 0, "R6 no strobes on code 11", stb_seen, 0);
    wr(8'h00);
    step(10);
    wr(8'h09);
    step(3);
    chk(cfg_q == 8'h09, "R3 select taken with enable", cfg_q, 8'h09);
    irq_seen = 0;
    @(negedge clk); #1 stop_status = 1'b1;
    step(8);
    @(negedge clk); #1 stop_status = 1'b0;
    step(3);
    @(negedge clk); #1 stop_status = 1'b1;
    step(4);
    @(negedge clk); #1 stop_status = 1'b0;
    step(3);
    chk(irq_seen == 2, "R8 one pulse per rise", irq_seen, 2);
    wr(8'h01);
    irq_seen = 0;
    @(negedge clk); #1 stop_status = 1'b1;
    step(5);
    @(negedge clk); #1 stop_status = 1'b0;
    step(3);
    chk(irq_seen == 0, "R9 no pulse with enable off", irq_seen, 0);
    wr(8'hE9);
    step(2);
    chk(cfg_q == 8'h09, "R2 reserved bits read zero", cfg_q, 8'h09);
    @(negedge clk); #1 sys_fast = 1'b1;
    step(200);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule